// File: doc/BRIEF.md
# Byte Shift Port with Strobe and Busy Hold-off

The block is a serial master that moves one byte out and one byte in per transfer over a clock/data-out/data-in trio, with the serial clock made by dividing the peripheral clock. Writing a byte while the port is idle starts a transfer. The port waits a short lead-in and then produces eight serial clock pulses. Each outgoing bit is presented after a falling edge, and each incoming bit is captured on a rising edge.

After the eighth rising edge the port raises a strobe pulse one serial period wide to tell the receiver that a byte is ready. If busy checking is enabled, the port then samples a busy line from the receiver at whole-period intervals. It keeps its completion flag low until the receiver lets go of that line. The completion flag tells the owning logic that it may write the next byte. The received byte is available on the parallel read port.

Top module: `shift_strobe_port`

## Requirements
- R1: While reset is asserted, `sck` is high and `stb`, `done`, `so` and `rd_data` are zero.
- R2: The serial half-period is H = 4 << `div_sel` peripheral clock cycles for `div_sel` 0 to 5, which divides by 8 to 256. Codes 6 and 7 behave as code 5. While shifting, every high time and every low time of `sck` is exactly H.
- R3: `sck` stays high while idle. A write (`wr_en` high while idle) starts a transfer, and the first falling edge of `sck` comes 3H cycles after the clock edge that accepted the write.
- R4: Each transfer has exactly eight `sck` pulses. `so` presents `wr_data` MSB first and changes only on falling edges of `sck`.
- R5: `si` is sampled on each rising edge of `sck`, MSB first. The assembled byte appears on `rd_data` on the eighth rising edge and is held otherwise.
- R6: `stb` rises H cycles after the eighth rising edge, stays high for 2H cycles, and is high only while `sck` is high.
- R7: With `busy_chk_en` high at the start, `busy_in` (active high) is sampled at 4H + 2nH cycles after the eighth rising edge, n = 0, 1, 2 and so on. `done` rises at the first sample that finds it low.
- R8: With `busy_chk_en` low at the start, `done` rises when `stb` falls, 3H cycles after the eighth rising edge, whatever the level of `busy_in`.
- R9: `done` falls on the edge that accepts a write and stays low until the transfer completes.
- R10: A write while a transfer is in progress is ignored. The data shifted out and all timing stay those of the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the transmit byte; starts a transfer when idle |
| wr_data | input | 8 | Byte to send |
| div_sel | input | 3 | Serial clock divider code, captured at start |
| busy_chk_en | input | 1 | Enables the busy hold-off, captured at start |
| rd_data | output | 8 | Last received byte |
| sck | output | 1 | Serial clock, idle high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| stb | output | 1 | End-of-byte strobe |
| busy_in | input | 1 | Receiver busy, active high |
| done | output | 1 | Transfer complete, next write allowed |

## Verification
Transfers are run with bytes chosen to expose bit order and stuck bits: alternating patterns, single set bits at either end, and all-ones and all-zeros in opposite directions on the two data lines. The divider codes cover the smallest, middle and largest ratios plus the two out-of-range codes. Each transfer measures edge spacing, which separates a wrong divide ratio or lead-in from a correct one. The busy line is held for zero to four sample points. With checking enabled this pins down the exact completion edge. With checking disabled and busy held high, it shows the line is ignored. A second write during shifting and a reset in mid-transfer cover the corner cases.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_STROBE,
        ST_WAITB
    } ssp_state_e;

endpackage

// File: rtl/ssp_half_tick.sv
module ssp_half_tick #(
    parameter int SEL_W     = 3,
    parameter int BASE_HALF = 4,
    parameter int NUM_SEL   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int MAX_HALF = BASE_HALF << (NUM_SEL - 1);
    localparam int CNT_W    = $clog2(MAX_HALF);
    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NUM_SEL - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SEL_W-1:0] sel_c;
    logic [CNT_W-1:0] last_c;

    always_comb begin
        sel_c  = (sel > TOP_SEL) ? TOP_SEL : sel;
        last_c = CNT_W'((BASE_HALF << sel_c) - 1);
        tick   = run && (cnt_q == last_c);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ssp_shift_reg.sv
module ssp_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_out,
    input  logic              sample_in,
    input  logic              si,
    output logic              so,
    output logic [DATA_W-1:0] rx_next
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              so;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        rx_next = {sh_q.rx[DATA_W-2:0], si};
        if (load) begin
            sh_d.tx = load_data;
        end
        if (shift_out) begin
            sh_d.so = sh_q.tx[DATA_W-1];
            sh_d.tx = {sh_q.tx[DATA_W-2:0], 1'b0};
        end
        if (sample_in) begin
            sh_d.rx = rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign so = sh_q.so;

endmodule

// File: rtl/shift_strobe_port.sv
module shift_strobe_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 3,
    parameter int BASE_HALF   = 4,
    parameter int NUM_SEL     = 6,
    parameter int LEAD_HALVES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              busy_chk_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              sck,
    output logic              so,
    input  logic              si,
    output logic              stb,
    input  logic              busy_in,
    output logic              done
);

    localparam int PH_W       = $clog2(2 * DATA_W);
    localparam int STB_HALVES = 2;
    localparam logic [PH_W-1:0] PH_LAST_RISE = PH_W'(2 * DATA_W - 2);
    localparam logic [PH_W-1:0] PH_LEAD_END  = PH_W'(LEAD_HALVES - 1);
    localparam logic [PH_W-1:0] PH_STB_END   = PH_W'(STB_HALVES);

    typedef struct packed {
        ssp_state_e             st;
        logic [PH_W-1:0]        ph;
        logic                   sck;
        logic                   stb;
        logic                   done;
        logic [DATA_W-1:0]      rd;
        logic [SEL_W-1:0]       sel;
        logic                   ben;
        logic [SYNC_STAGES-1:0] bsync;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tick;
    logic              load;
    logic              fall;
    logic              rise;
    logic [DATA_W-1:0] rx_next;
    logic              busy_s;

    ssp_half_tick #(
        .SEL_W    (SEL_W),
        .BASE_HALF(BASE_HALF),
        .NUM_SEL  (NUM_SEL)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.st != ST_IDLE),
        .sel  (ctl_q.sel),
        .tick (tick)
    );

    ssp_shift_reg #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_data(wr_data),
        .shift_out(fall),
        .sample_in(rise),
        .si       (si),
        .so       (so),
        .rx_next  (rx_next)
    );

    assign busy_s = ctl_q.bsync[SYNC_STAGES-1];

    always_comb begin
        ctl_d       = ctl_q;
        load        = 1'b0;
        fall        = 1'b0;
        rise        = 1'b0;
        ctl_d.bsync = {ctl_q.bsync[SYNC_STAGES-2:0], busy_in};

        case (ctl_q.st)
            ST_IDLE: begin
                if (wr_en) begin
                    load       = 1'b1;
                    ctl_d.st   = ST_LEAD;
                    ctl_d.ph   = '0;
                    ctl_d.sel  = div_sel;
                    ctl_d.ben  = busy_chk_en;
                    ctl_d.done = 1'b0;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (ctl_q.ph == PH_LEAD_END) begin
                        fall      = 1'b1;
                        ctl_d.sck = 1'b0;
                        ctl_d.st  = ST_SHIFT;
                        ctl_d.ph  = '0;
                    end else begin
                        ctl_d.ph = ctl_q.ph + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!ctl_q.ph[0]) begin
                        rise      = 1'b1;
                        ctl_d.sck = 1'b1;
                        if (ctl_q.ph == PH_LAST_RISE) begin
                            ctl_d.rd = rx_next;
                            ctl_d.st = ST_STROBE;
                            ctl_d.ph = '0;
                        end else begin
                            ctl_d.ph = ctl_q.ph + 1'b1;
                        end
                    end else begin
                        fall      = 1'b1;
                        ctl_d.sck = 1'b0;
                        ctl_d.ph  = ctl_q.ph + 1'b1;
                    end
                end
            end
            ST_STROBE: begin
                if (tick) begin
                    if (ctl_q.ph == '0) begin
                        ctl_d.stb = 1'b1;
                        ctl_d.ph  = ctl_q.ph + 1'b1;
                    end else if (ctl_q.ph == PH_STB_END) begin
                        ctl_d.stb = 1'b0;
                        ctl_d.ph  = '0;
                        if (ctl_q.ben) begin
                            ctl_d.st = ST_WAITB;
                        end else begin
                            ctl_d.done = 1'b1;
                            ctl_d.st   = ST_IDLE;
                        end
                    end else begin
                        ctl_d.ph = ctl_q.ph + 1'b1;
                    end
                end
            end
            ST_WAITB: begin
                if (tick) begin
                    if (ctl_q.ph[0]) begin
                        ctl_d.ph = '0;
                    end else if (!busy_s) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = ST_IDLE;
                    end else begin
                        ctl_d.ph = PH_W'(1);
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.sck <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sck     = ctl_q.sck;
    assign stb     = ctl_q.stb;
    assign done    = ctl_q.done;
    assign rd_data = ctl_q.rd;

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              so,
    input logic              stb,
    input logic              done,
    input logic [DATA_W-1:0] rd_data
);

    p_stb_sck_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> sck);

    p_stb_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |=> stb);

    p_so_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(so));

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sck |-> $stable(rd_data));

    p_done_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sck);

    p_done_no_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !stb);

endmodule

bind shift_strobe_port ssp_port_chk #(
    .DATA_W(DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (sck),
    .so     (so),
    .stb    (stb),
    .done   (done),
    .rd_data(rd_data)
);

// File: tb/shift_strobe_port_bench.sv
module shift_strobe_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 7;
    // {div_sel[3], tx[8], rx[8], busy_chk_en[1], busy samples held[4]}
    localparam logic [23:0] VECS [NVEC] = '{
        {3'd0, 8'hA5, 8'h3C, 1'b1, 4'd0},
        {3'd1, 8'h81, 8'h7E, 1'b1, 4'd2},
        {3'd2, 8'hFF, 8'h00, 1'b0, 4'd3},
        {3'd5, 8'h00, 8'hFF, 1'b1, 4'd1},
        {3'd7, 8'h5A, 8'hC3, 1'b1, 4'd0},
        {3'd3, 8'h96, 8'h69, 1'b1, 4'd4},
        {3'd6, 8'h01, 8'h80, 1'b0, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] div_sel = 3'd0;
    logic       busy_chk_en = 1'b0;
    logic       si = 1'b0;
    logic       busy_in = 1'b0;
    logic [7:0] rd_data;
    logic       sck, so, stb, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    bit         mon_on = 1'b0;
    bit         busy_lvl = 1'b0;
    int         h_exp = 4;
    logic [7:0] rx_pat = 8'h00;
    int         nbusy_m = 0;
    int         falls, rises, t_fall1, t_rise8, t_stb_r, t_stb_f, t_done, last_edge;
    int         rel_at = -1;
    bit         width_bad;
    logic [7:0] so_got;
    logic       prev_sck = 1'b1, prev_stb = 1'b0, prev_done = 1'b0;

    shift_strobe_port u_shift_strobe_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .div_sel    (div_sel),
        .busy_chk_en(busy_chk_en),
        .rd_data    (rd_data),
        .sck        (sck),
        .so         (so),
        .si         (si),
        .stb        (stb),
        .busy_in    (busy_in),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Slave model and edge timer, sampled between clock edges
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_sck && !sck) begin
                if (falls == 0) t_fall1 = cyc;
                else if (cyc - last_edge != h_exp) width_bad = 1'b1;
                last_edge = cyc;
                if (falls < 8) si = rx_pat[7 - falls];
                falls++;
            end
            if (!prev_sck && sck) begin
                if (cyc - last_edge != h_exp) width_bad = 1'b1;
                last_edge = cyc;
                so_got = {so_got[6:0], so};
                rises++;
                if (rises == 8) t_rise8 = cyc;
            end
            if (!prev_stb && stb) t_stb_r = cyc;
            if (prev_stb && !stb) begin
                t_stb_f = cyc;
                rel_at  = cyc + 2 * nbusy_m * h_exp;
            end
            if (!prev_done && done && t_done < 0) t_done = cyc;
        end
        busy_in   = busy_lvl && !(rel_at >= 0 && cyc >= rel_at);
        prev_sck  = sck;
        prev_stb  = stb;
        prev_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(input int vi, input logic [2:0] sel, input logic [7:0] tx,
                            input logic [7:0] rx, input logic ben, input int nb,
                            input bit poke);
        int h, t0, exp_done;
        h = 4 << ((sel > 3'd5) ? 5 : int'(sel));
        @(negedge clk);
        h_exp = h; rx_pat = rx; nbusy_m = nb;
        falls = 0; rises = 0; t_fall1 = -1; t_rise8 = -1; t_stb_r = -1;
        t_stb_f = -1; t_done = -1; last_edge = 0; rel_at = -1;
        width_bad = 1'b0; so_got = 8'h00;
        busy_lvl = (nb > 0);
        mon_on = 1'b1;
        div_sel = sel; busy_chk_en = ben; wr_data = tx; wr_en = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
        div_sel = ~sel;
        busy_chk_en = ~ben;
        chk(done == 1'b0, $sformatf("R9 vec%0d done cleared by write", vi), int'(done), 0);
        if (poke) begin
            repeat (5 * h) @(negedge clk);
            wr_data = ~tx; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        mon_on = 1'b0;
        busy_lvl = 1'b0;
        exp_done = ben ? (4 * h + 2 * nb * h) : 3 * h;
        chk(t_fall1 - t0 == 3 * h, $sformatf("R3 vec%0d lead-in", vi), t_fall1 - t0, 3 * h);
        chk(!width_bad, $sformatf("R2 vec%0d sck half-period", vi), int'(width_bad), 0);
        chk(falls == 8 && rises == 8, $sformatf("R4 vec%0d clock count", vi), rises, 8);
        chk(so_got == tx, $sformatf("R4 R10 vec%0d so byte", vi), so_got, tx);
        chk(rd_data == rx, $sformatf("R5 vec%0d rd_data", vi), rd_data, rx);
        chk(t_stb_r - t_rise8 == h, $sformatf("R6 vec%0d stb delay", vi), t_stb_r - t_rise8, h);
        chk(t_stb_f - t_stb_r == 2 * h, $sformatf("R6 vec%0d stb width", vi), t_stb_f - t_stb_r, 2 * h);
        chk(t_done - t_rise8 == exp_done, $sformatf("R7 R8 vec%0d done time", vi), t_done - t_rise8, exp_done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sck == 1'b1, "R1 sck in reset", int'(sck), 1);
        chk(stb == 1'b0 && done == 1'b0, "R1 stb/done in reset", int'({stb, done}), 0);
        chk(so == 1'b0 && rd_data == 8'h00, "R1 so/rd_data in reset", int'({so, rd_data}), 0);
        rst_n = 1'b1;
        // R3: idle without a write keeps sck high
        begin
            bit low_seen = 1'b0;
            repeat (40) begin
                @(negedge clk);
                if (!sck) low_seen = 1'b1;
            end
            chk(!low_seen, "R3 sck idle high", int'(low_seen), 0);
        end
        for (int i = 0; i < NVEC; i++) begin
            run_xfer(i, VECS[i][23:21], VECS[i][20:13], VECS[i][12:5],
                     VECS[i][4], int'(VECS[i][3:0]), 1'b0);
        end
        // R10: second write during shifting is ignored
        run_xfer(100, 3'd0, 8'hC6, 8'h1D, 1'b1, 1, 1'b1);
        // R1: reset in mid-transfer returns to idle state
        @(negedge clk);
        div_sel = 3'd1; wr_data = 8'hF0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (70) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sck == 1'b1 && stb == 1'b0, "R1 sck/stb after mid reset", int'({sck, stb}), 2);
        chk(done == 1'b0 && rd_data == 8'h00, "R1 done/rd_data after mid reset", int'({done, rd_data}), 0);
        rst_n = 1'b1;
        run_xfer(101, 3'd0, 8'h3B, 8'hE4, 1'b0, 0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule